// File: doc/BRIEF.md
# Sectored Flash Program/Erase Engine

This block is the internal write engine of a small serial NOR-style memory. A command front-end hands it one of three requests: program a run of bytes inside one 256-byte page, erase the sector that holds a given address, or erase the whole 256 KB array. The engine applies NOR write rules to a behavioural byte array. Programming can only clear bits. Erasing returns bytes to FFh. The engine holds a busy flag for a cycle count set by a parameter, which stands in for the real program and erase times.

The address space has eight sectors of unequal size: three of 64 KB, one of 32 KB, one of 16 KB, one of 8 KB and two of 4 KB. A parameter places the small sectors either at the bottom or at the top of the address range. A combinational lookup port returns the sector index of any 18-bit address, for use by protection logic outside this block.

To keep simulation small, the array only stores a window of `MEM_BYTES` bytes that starts at `WIN_BASE`. Addresses outside the window read as FFh, and programming them has no stored effect. Program data arrives one byte per cycle after the request has been accepted.

Top module: `flash_write_engine`

## Requirements
- R1: After reset, `busy` and `req_reject` are low and every byte reads FFh.
- R2: With `TOP_BOOT`=0, `lookup_sector` is 0 for 0x00000-0x00FFF, 1 for 0x01000-0x01FFF, 2 for 0x02000-0x03FFF, 3 for 0x04000-0x07FFF, 4 for 0x08000-0x0FFFF, and 5, 6, 7 for the 64 KB blocks starting at 0x10000, 0x20000 and 0x30000.
- R3: With `TOP_BOOT`=1, the map is mirrored. The index is 0, 1, 2 for the 64 KB blocks from 0x00000. It is 3 for 0x30000-0x37FFF, 4 for 0x38000-0x3BFFF, 5 for 0x3C000-0x3DFFF, 6 for 0x3E000-0x3EFFF and 7 for 0x3F000-0x3FFFF.
- R4: A program request (`req_op`=01) stores the old byte ANDed with each data byte taken on a cycle with `wr_valid` high. No byte changes while the engine is idle.
- R5: A program request writes `req_len_m1`+1 bytes (1 to 256). It starts at `req_addr` and increments only the low 8 address bits, so a run wraps to the start of the same page and never reaches the next page.
- R6: A sector erase (`req_op`=10) sets every byte of the sector holding `req_addr` to FFh and leaves bytes of other sectors unchanged.
- R7: A bulk erase (`req_op`=11) sets every byte to FFh.
- R8: `busy` rises the cycle after a request is accepted and stays high while program data loads. After the final data byte it stays high for exactly `PROG_CYCLES` cycles.
- R9: For an erase, `busy` stays high for max(erase cycle count, `MEM_BYTES`) cycles after acceptance. The erase cycle count is `SERASE_CYCLES` for a sector erase and `BERASE_CYCLES` for a bulk erase.
- R10: A request (op not 00) presented while `busy` is high is ignored and `req_reject` pulses high the following cycle.
- R11: `req_op`=00 is no request: it starts nothing and raises no reject.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Request strobe |
| req_op | input | 2 | 00 none, 01 program, 10 sector erase, 11 bulk erase |
| req_addr | input | 18 | Start address, or an address inside the sector to erase |
| req_len_m1 | input | 8 | Program byte count minus one |
| wr_valid | input | 1 | Program data byte valid |
| wr_data | input | 8 | Program data byte |
| busy | output | 1 | Internal cycle in progress |
| req_reject | output | 1 | One-cycle pulse: request refused while busy |
| lookup_addr | input | 18 | Address to classify |
| lookup_sector | output | 3 | Sector index of `lookup_addr` |
| rd_addr | input | 18 | Array read address |
| rd_data | output | 8 | Array byte at `rd_addr` |

## Verification
The main instance uses bottom boot, a 512-byte window at 0x00F00, `PROG_CYCLES`=5, `SERASE_CYCLES`=600 and `BERASE_CYCLES`=700. The window covers the whole page 0x0F00-0x0FFF and the whole page 0x1000-0x10FF, so one window shows page wrap and a 4 KB sector boundary. Both erase counts exceed the 512-cycle array scan, so the measured busy lengths expose the parameter counts. A second instance built with top boot serves only the mirrored sector lookup.

// File: rtl/fwe_pkg.sv
package fwe_pkg;
    localparam int ADDR_W = 18;
    localparam int COL_W  = 8;
    localparam int PAGE_W = ADDR_W - COL_W;
    localparam int SECT_W = 3;

    typedef enum logic [1:0] {
        OP_NONE   = 2'b00,
        OP_PROG   = 2'b01,
        OP_SERASE = 2'b10,
        OP_BERASE = 2'b11
    } op_e;

    typedef enum logic [1:0] {
        ST_IDLE,
        ST_LOAD,
        ST_PWAIT,
        ST_ERASE
    } state_e;

    // Sector index with the small sectors at the low end of the space.
    function automatic logic [SECT_W-1:0] low_boot_sector(input logic [ADDR_W-1:0] a);
        logic [SECT_W-1:0] s;
        if (a[17:16] != 2'b00)
            s = 3'(3'd4 + {1'b0, a[17:16]});
        else if (a[15])
            s = 3'd4;
        else if (a[14])
            s = 3'd3;
        else if (a[13])
            s = 3'd2;
        else if (a[12])
            s = 3'd1;
        else
            s = 3'd0;
        return s;
    endfunction
endpackage

// File: rtl/fwe_sector_map.sv
module fwe_sector_map
    import fwe_pkg::*;
#(
    parameter bit TOP_BOOT = 1'b0
) (
    input  logic [ADDR_W-1:0] addr,
    output logic [SECT_W-1:0] sector
);
    generate
        if (TOP_BOOT) begin : g_top
            // Mirror: complement the address, then reverse the index order.
            always_comb sector = 3'(3'd7 - low_boot_sector(~addr));
        end else begin : g_bottom
            always_comb sector = low_boot_sector(addr);
        end
    endgenerate
endmodule

// File: rtl/fwe_array.sv
module fwe_array #(
    parameter int MEM_BYTES = 1024,
    localparam int IDX_W = $clog2(MEM_BYTES)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             prog_en,
    input  logic [IDX_W-1:0] prog_idx,
    input  logic [7:0]       prog_data,
    input  logic             erase_en,
    input  logic [IDX_W-1:0] erase_idx,
    input  logic [IDX_W-1:0] rd_idx,
    output logic [7:0]       rd_data
);
    logic [7:0] mem_q [MEM_BYTES];

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < MEM_BYTES; i++) mem_q[i] <= 8'hFF;
        end else if (prog_en) begin
            mem_q[prog_idx] <= mem_q[prog_idx] & prog_data;
        end else if (erase_en) begin
            mem_q[erase_idx] <= 8'hFF;
        end
    end

    assign rd_data = mem_q[rd_idx];
endmodule

// File: rtl/flash_write_engine.sv
module flash_write_engine
    import fwe_pkg::*;
#(
    parameter bit              TOP_BOOT      = 1'b0,
    parameter int              MEM_BYTES     = 1024,
    parameter logic [17:0]     WIN_BASE      = 18'h00000,
    parameter int              PROG_CYCLES   = 8,
    parameter int              SERASE_CYCLES = 64,
    parameter int              BERASE_CYCLES = 128
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        req_valid,
    input  logic [1:0]  req_op,
    input  logic [17:0] req_addr,
    input  logic [7:0]  req_len_m1,
    input  logic        wr_valid,
    input  logic [7:0]  wr_data,
    output logic        busy,
    output logic        req_reject,
    input  logic [17:0] lookup_addr,
    output logic [2:0]  lookup_sector,
    input  logic [17:0] rd_addr,
    output logic [7:0]  rd_data
);
    localparam int IDX_W  = $clog2(MEM_BYTES);
    localparam int MAX_C1 = (PROG_CYCLES > SERASE_CYCLES) ? PROG_CYCLES : SERASE_CYCLES;
    localparam int MAX_C  = (MAX_C1 > BERASE_CYCLES) ? MAX_C1 : BERASE_CYCLES;
    localparam int CNT_W  = $clog2(MAX_C + 1);
    localparam logic [ADDR_W:0]  WIN_LO   = {1'b0, WIN_BASE};
    localparam logic [ADDR_W:0]  WIN_HI   = WIN_LO + (ADDR_W+1)'(MEM_BYTES);
    localparam logic [IDX_W-1:0] LAST_IDX = IDX_W'(MEM_BYTES - 1);

    typedef struct packed {
        state_e             state;
        logic [PAGE_W-1:0]  page;
        logic [COL_W-1:0]   col;
        logic [COL_W-1:0]   remain;
        logic [CNT_W-1:0]   cnt;
        logic [IDX_W-1:0]   scan_idx;
        logic               scan_done;
        logic [SECT_W-1:0]  target;
        logic               bulk;
        logic               reject;
    } eng_t;

    eng_t q, d;

    function automatic logic in_win(input logic [ADDR_W-1:0] a);
        return ({1'b0, a} >= WIN_LO) && ({1'b0, a} < WIN_HI);
    endfunction

    // Sector lookups: external port, request address, erase scan address.
    logic [SECT_W-1:0] req_sector, scan_sector;
    logic [ADDR_W-1:0] scan_addr, prog_addr;

    assign scan_addr = WIN_BASE + ADDR_W'(q.scan_idx);
    assign prog_addr = {q.page, q.col};

    fwe_sector_map #(.TOP_BOOT(TOP_BOOT)) i_map_lookup (.addr(lookup_addr), .sector(lookup_sector));
    fwe_sector_map #(.TOP_BOOT(TOP_BOOT)) i_map_req    (.addr(req_addr),    .sector(req_sector));
    fwe_sector_map #(.TOP_BOOT(TOP_BOOT)) i_map_scan   (.addr(scan_addr),   .sector(scan_sector));

    logic             prog_en, erase_en, accept, last_scan;
    logic [7:0]       arr_rd;
    logic [IDX_W-1:0] prog_idx, rd_idx;

    assign prog_idx = IDX_W'(prog_addr - WIN_BASE);
    assign rd_idx   = IDX_W'(rd_addr - WIN_BASE);

    fwe_array #(.MEM_BYTES(MEM_BYTES)) i_array (
        .clk       (clk),
        .rst_n     (rst_n),
        .prog_en   (prog_en),
        .prog_idx  (prog_idx),
        .prog_data (wr_data),
        .erase_en  (erase_en),
        .erase_idx (q.scan_idx),
        .rd_idx    (rd_idx),
        .rd_data   (arr_rd)
    );

    always_comb begin
        d         = q;
        d.reject  = 1'b0;
        prog_en   = 1'b0;
        erase_en  = 1'b0;
        accept    = req_valid && (req_op != OP_NONE);
        last_scan = q.scan_done || (q.scan_idx == LAST_IDX);

        unique case (q.state)
            ST_IDLE: begin
                if (accept) begin
                    d.page      = req_addr[ADDR_W-1:COL_W];
                    d.col       = req_addr[COL_W-1:0];
                    d.remain    = req_len_m1;
                    d.target    = req_sector;
                    d.scan_idx  = '0;
                    d.scan_done = 1'b0;
                    d.bulk      = (req_op == OP_BERASE);
                    if (req_op == OP_PROG) begin
                        d.state = ST_LOAD;
                    end else begin
                        d.state = ST_ERASE;
                        d.cnt   = (req_op == OP_BERASE) ? CNT_W'(BERASE_CYCLES - 1)
                                                        : CNT_W'(SERASE_CYCLES - 1);
                    end
                end
            end
            ST_LOAD: begin
                if (wr_valid) begin
                    prog_en = in_win(prog_addr);
                    d.col   = q.col + 1'b1;          // wraps inside the page
                    if (q.remain == '0) begin
                        d.state = ST_PWAIT;
                        d.cnt   = CNT_W'(PROG_CYCLES - 1);
                    end else begin
                        d.remain = q.remain - 1'b1;
                    end
                end
            end
            ST_PWAIT: begin
                if (q.cnt == '0) d.state = ST_IDLE;
                else             d.cnt   = q.cnt - 1'b1;
            end
            ST_ERASE: begin
                if (!q.scan_done) begin
                    erase_en = q.bulk || (scan_sector == q.target);
                    if (q.scan_idx == LAST_IDX) d.scan_done = 1'b1;
                    else                        d.scan_idx  = q.scan_idx + 1'b1;
                end
                if (q.cnt == '0) begin
                    if (last_scan) d.state = ST_IDLE;
                end else begin
                    d.cnt = q.cnt - 1'b1;
                end
            end
            default: d.state = ST_IDLE;
        endcase

        if ((q.state != ST_IDLE) && accept) d.reject = 1'b1;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            q       <= '0;
            q.state <= ST_IDLE;
        end else begin
            q <= d;
        end
    end

    assign busy       = (q.state != ST_IDLE);
    assign req_reject = q.reject;
    assign rd_data    = in_win(rd_addr) ? arr_rd : 8'hFF;
endmodule

// File: rtl/fwe_checker.sv
module fwe_checker (
    input logic        clk,
    input logic        rst_n,
    input logic        req_valid,
    input logic [1:0]  req_op,
    input logic        busy,
    input logic        req_reject,
    input logic [17:0] lookup_addr,
    input logic [2:0]  lookup_sector,
    input logic [17:0] rd_addr,
    input logic [7:0]  rd_data
);
    assert_accept_busy_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && !busy && req_op != 2'b00) |=> busy);

    assert_reject_busy_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && busy && req_op != 2'b00) |=> req_reject);

    assert_no_spurious_reject_R11: assert property (@(posedge clk) disable iff (!rst_n)
        (!busy || !req_valid || req_op == 2'b00) |=> !req_reject);

    assert_idle_hold_R4: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(!busy && !req_valid) && $stable(rd_addr)) |-> $stable(rd_data));

    assert_lookup_ends_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (lookup_addr == 18'h00000) |-> (lookup_sector == 3'd0));

    assert_lookup_top_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (lookup_addr == 18'h3FFFF) |-> (lookup_sector == 3'd7));
endmodule

bind flash_write_engine fwe_checker i_fwe_checker (
    .clk           (clk),
    .rst_n         (rst_n),
    .req_valid     (req_valid),
    .req_op        (req_op),
    .busy          (busy),
    .req_reject    (req_reject),
    .lookup_addr   (lookup_addr),
    .lookup_sector (lookup_sector),
    .rd_addr       (rd_addr),
    .rd_data       (rd_data)
);

// File: tb/test_flash_write_engine.sv
module test_flash_write_engine;
    localparam int CLK_PERIOD = 10;
    localparam int PROG_C = 5;
    localparam int SE_C   = 600;
    localparam int BE_C   = 700;

    typedef struct packed {
        logic [17:0] addr;
        logic [2:0]  bot;
        logic [2:0]  top;
    } vec_t;

    localparam int NVEC = 17;
    localparam vec_t VECS [NVEC] = '{
        '{18'h00000, 3'd0, 3'd0}, '{18'h00FFF, 3'd0, 3'd0}, '{18'h01000, 3'd1, 3'd0},
        '{18'h02000, 3'd2, 3'd0}, '{18'h03FFF, 3'd2, 3'd0}, '{18'h04000, 3'd3, 3'd0},
        '{18'h08000, 3'd4, 3'd0}, '{18'h0FFFF, 3'd4, 3'd0}, '{18'h10000, 3'd5, 3'd1},
        '{18'h2ABCD, 3'd6, 3'd2}, '{18'h30000, 3'd7, 3'd3}, '{18'h37FFF, 3'd7, 3'd3},
        '{18'h38000, 3'd7, 3'd4}, '{18'h3C000, 3'd7, 3'd5}, '{18'h3E000, 3'd7, 3'd6},
        '{18'h3F000, 3'd7, 3'd7}, '{18'h3FFFF, 3'd7, 3'd7}
    };

    logic        clk = 1'b0, rst_n = 1'b0;
    logic        req_valid = 1'b0, wr_valid = 1'b0;
    logic [1:0]  req_op = 2'b00;
    logic [17:0] req_addr = '0, lookup_addr = '0, rd_addr = '0;
    logic [7:0]  req_len_m1 = '0, wr_data = '0;
    logic        busy, req_reject, busy_t, reject_t;
    logic [2:0]  lookup_sector, sector_t;
    logic [7:0]  rd_data, rd_t;

    int checks = 0, errors = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    flash_write_engine #(
        .TOP_BOOT(1'b0), .MEM_BYTES(512), .WIN_BASE(18'h00F00),
        .PROG_CYCLES(PROG_C), .SERASE_CYCLES(SE_C), .BERASE_CYCLES(BE_C)
    ) i_flash_write_engine (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_op(req_op),
        .req_addr(req_addr), .req_len_m1(req_len_m1), .wr_valid(wr_valid),
        .wr_data(wr_data), .busy(busy), .req_reject(req_reject),
        .lookup_addr(lookup_addr), .lookup_sector(lookup_sector),
        .rd_addr(rd_addr), .rd_data(rd_data)
    );

    flash_write_engine #(.TOP_BOOT(1'b1)) i_top_boot (
        .clk(clk), .rst_n(rst_n), .req_valid(1'b0), .req_op(2'b00),
        .req_addr(18'h0), .req_len_m1(8'h0), .wr_valid(1'b0),
        .wr_data(8'h0), .busy(busy_t), .req_reject(reject_t),
        .lookup_addr(lookup_addr), .lookup_sector(sector_t),
        .rd_addr(rd_addr), .rd_data(rd_t)
    );

    task automatic check(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic rd(input logic [17:0] a, output logic [7:0] v);
        rd_addr = a;
        #1;
        v = rd_data;
    endtask

    task automatic check_byte(input string req, input logic [17:0] a, input logic [7:0] exp);
        logic [7:0] v;
        rd(a, v);
        check(req, int'(v), int'(exp));
    endtask

    task automatic wait_idle(output int n);
        n = 0;
        while (busy && n < 5000) begin
            n++;
            @(negedge clk);
        end
    endtask

    // Starts a program request and streams its bytes; ends at the negedge after the last byte.
    task automatic prog_load(input logic [17:0] a, input int n, input logic [31:0] bytes);
        @(negedge clk);
        req_valid = 1'b1; req_op = 2'b01; req_addr = a; req_len_m1 = 8'(n - 1);
        @(negedge clk);
        req_valid = 1'b0;
        check("R8 busy after program accept", int'(busy), 1);
        for (int i = 0; i < n; i++) begin
            wr_valid = 1'b1;
            wr_data  = bytes[8*i +: 8];
            @(negedge clk);
        end
        wr_valid = 1'b0;
    endtask

    task automatic erase(input logic [1:0] op, input logic [17:0] a, input int exp_len, input string req);
        int n;
        @(negedge clk);
        req_valid = 1'b1; req_op = op; req_addr = a;
        @(negedge clk);
        req_valid = 1'b0;
        wait_idle(n);
        check(req, n, exp_len);
    endtask

    initial begin
        #(CLK_PERIOD * 150000);
        errors++;
        $display("FAIL watchdog expired");
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        int n;
        logic [7:0] v;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R1: reset state
        check("R1 busy after reset", int'(busy), 0);
        check("R1 reject after reset", int'(req_reject), 0);
        check_byte("R1 erased at 0x00F00", 18'h00F00, 8'hFF);
        check_byte("R1 erased at 0x010FF", 18'h010FF, 8'hFF);

        // R2 / R3: sector lookup table walk
        for (int i = 0; i < NVEC; i++) begin
            lookup_addr = VECS[i].addr;
            #1;
            check("R2 bottom-boot sector", int'(lookup_sector), int'(VECS[i].bot));
            check("R3 top-boot sector", int'(sector_t), int'(VECS[i].top));
        end

        // R5 wrap + R8 program busy length
        prog_load(18'h00FFE, 4, 32'hF00F3CA5);
        wait_idle(n);
        check("R8 program busy cycles", n, PROG_C);
        check_byte("R5 first byte", 18'h00FFE, 8'hA5);
        check_byte("R5 page end", 18'h00FFF, 8'h3C);
        check_byte("R5 wrapped to page start", 18'h00F00, 8'h0F);
        check_byte("R5 wrapped second", 18'h00F01, 8'hF0);
        check_byte("R5 untouched after run", 18'h00F02, 8'hFF);
        check_byte("R5 next page untouched", 18'h01000, 8'hFF);

        // R4: program ANDs with old contents
        prog_load(18'h00FFE, 1, 32'h0000005A);
        wait_idle(n);
        check_byte("R4 AND result", 18'h00FFE, 8'h00);
        check_byte("R4 neighbour kept", 18'h00FFF, 8'h3C);

        // R10: request while busy is refused and has no effect
        prog_load(18'h01000, 2, 32'h00003412);
        check("R10 busy during wait", int'(busy), 1);
        req_valid = 1'b1; req_op = 2'b10; req_addr = 18'h01000;
        @(negedge clk);
        req_valid = 1'b0;
        check("R10 reject pulse", int'(req_reject), 1);
        @(negedge clk);
        check("R10 reject one cycle", int'(req_reject), 0);
        wait_idle(n);
        @(negedge clk);
        check("R10 busy ended", int'(busy), 0);
        check_byte("R10 refused erase left data", 18'h01000, 8'h12);
        check_byte("R10 second byte", 18'h01001, 8'h34);

        // R11: op 00 does nothing
        @(negedge clk);
        req_valid = 1'b1; req_op = 2'b00; req_addr = 18'h01000;
        @(negedge clk);
        req_valid = 1'b0;
        check("R11 no busy", int'(busy), 0);
        check("R11 no reject", int'(req_reject), 0);
        check_byte("R11 data kept", 18'h01000, 8'h12);

        // R6 / R9: sector erase of sector 1 only
        erase(2'b10, 18'h01005, SE_C, "R9 sector erase busy cycles");
        check_byte("R6 erased 0x01000", 18'h01000, 8'hFF);
        check_byte("R6 erased 0x01001", 18'h01001, 8'hFF);
        check_byte("R6 other sector kept 0x00FFF", 18'h00FFF, 8'h3C);
        check_byte("R6 other sector kept 0x00F00", 18'h00F00, 8'h0F);

        // R7 / R9: bulk erase
        erase(2'b11, 18'h00000, BE_C, "R9 bulk erase busy cycles");
        check_byte("R7 erased 0x00F00", 18'h00F00, 8'hFF);
        check_byte("R7 erased 0x00FFF", 18'h00FFF, 8'hFF);
        rd(18'h00F01, v);
        check("R7 erased 0x00F01", int'(v), 8'hFF);

        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule